// File: doc/BRIEF.md
# Integer ALU with Immediate Handling

This block is the combinational 32-bit integer execution unit of a small RISC core. Each cycle it receives an operation code, two register operands, a 16-bit immediate and a flag choosing whether the second operand comes from the register or from the immediate. It returns a 32-bit result and a flag that marks the operation as illegal.

The operations are add, subtract, the three bitwise operations, four shift forms, load-high-immediate, multiply, and signed and unsigned divide. How the immediate is widened depends on the operation:

- Bitwise, multiply and divide operations zero-extend the immediate.
- Add and subtract sign-extend it.
- Shifts and rotates use only its five low bits.

A divide by zero produces no result value. Instead it raises the illegal flag, so that the surrounding core can trap. Decode, register file, pipelining and trap vectoring are outside the block.

Top module: `alu_core`

## Requirements
- R1: With `useImm`=0, operation code 0 yields `srcA + srcB` and code 1 yields `srcA - srcB`, both modulo 2^32.
- R2: Code 2 (and), code 3 (or) and code 4 (xor) combine `srcA` with `srcB`. When `useImm`=1 they use `{16'h0, immVal}` instead.
- R3: With `useImm`=1, codes 0 and 1 add or subtract the sign-extended immediate `{{16{immVal[15]}}, immVal}`.
- R4: The shift amount is `srcB[4:0]`, or `immVal[4:0]` when `useImm`=1, and all higher bits are ignored. Code 5 shifts left and fills with zeros. Code 6 shifts right and fills with zeros. Code 7 shifts right and fills with `srcA[31]`.
- R5: Code 8 rotates `srcA` right by the shift amount of R4. The bits that leave at bit 0 re-enter at bit 31.
- R6: Code 9 returns `{immVal, 16'h0}`. It ignores `srcA`, `srcB` and `useImm`.
- R7: Code 10 returns the low 32 bits of `srcA` times the second operand. With `useImm`=1 the second operand is the zero-extended immediate.
- R8: Code 11 is a signed divide of `srcA` by the second operand (the zero-extended immediate when `useImm`=1). The quotient truncates toward zero, and 0x80000000 / -1 gives 0x80000000.
- R9: Code 12 is an unsigned divide of `srcA` by the second operand, with the same operand choice as R8.
- R10: Code 11 or 12 with a second operand of zero sets `illegalOp`=1 and drives `result`=0.
- R11: Codes 13 to 15 are undefined. They set `illegalOp`=1 and drive `result`=0.
- R12: `illegalOp` is 0 for every case not covered by R10 or R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see requirements) |
| useImm | input | 1 | 1 selects the immediate as second operand |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand |
| immVal | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| illegalOp | output | 1 | Illegal operation / zero divisor trap |

## Verification
The hardest cases to reach are at the edges of the divider and the shifter: the signed quotient that overflows (0x80000000 / -1), negative operands that must truncate toward zero, and immediate shift amounts whose upper immediate bits must be ignored. Random operands almost never produce these. Directed vectors place each one explicitly. After that, random traffic biases the divisor toward zero and toward small values, so that the trap path and the sign combinations recur many times, and the undefined codes are included.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SLL   = 4'd5,
    OP_SRL   = 4'd6,
    OP_SRA   = 4'd7,
    OP_ROR   = 4'd8,
    OP_MOVHI = 4'd9,
    OP_MUL   = 4'd10,
    OP_DIV   = 4'd11,
    OP_DIVU  = 4'd12
  } alu_op_e;

  // where the second operand comes from
  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_ZEXT  = 2'd1,
    SRC_SEXT  = 2'd2,
    SRC_SHAMT = 2'd3
  } opb_src_e;

  typedef enum logic [2:0] {
    UNIT_ADD   = 3'd0,
    UNIT_LOGIC = 3'd1,
    UNIT_SHIFT = 3'd2,
    UNIT_HIGH  = 3'd3,
    UNIT_MUL   = 3'd4,
    UNIT_DIV   = 3'd5,
    UNIT_NONE  = 3'd6
  } unit_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } logic_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2,
    SH_ROT  = 2'd3
  } shift_e;

  // strobes from control to datapath
  typedef struct packed {
    opb_src_e bSrc;
    unit_e    unit;
    logic     negB;
    logic_e   logicKind;
    shift_e   shiftKind;
    logic     divSigned;
    logic     badOp;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       useImm,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.bSrc      = SRC_REG;
    ctrl.unit      = UNIT_NONE;
    ctrl.logicKind = LOG_AND;
    ctrl.shiftKind = SH_LEFT;
    ctrl.badOp     = 1'b0;
    case (opSel)
      OP_ADD, OP_SUB: begin
        ctrl.unit = UNIT_ADD;
        ctrl.negB = (opSel == OP_SUB);
        ctrl.bSrc = useImm ? SRC_SEXT : SRC_REG;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.unit = UNIT_LOGIC;
        ctrl.bSrc = useImm ? SRC_ZEXT : SRC_REG;
        case (opSel)
          OP_AND:  ctrl.logicKind = LOG_AND;
          OP_OR:   ctrl.logicKind = LOG_OR;
          default: ctrl.logicKind = LOG_XOR;
        endcase
      end
      OP_SLL, OP_SRL, OP_SRA, OP_ROR: begin
        ctrl.unit = UNIT_SHIFT;
        ctrl.bSrc = useImm ? SRC_SHAMT : SRC_REG;
        case (opSel)
          OP_SLL:  ctrl.shiftKind = SH_LEFT;
          OP_SRL:  ctrl.shiftKind = SH_RLOG;
          OP_SRA:  ctrl.shiftKind = SH_RARI;
          default: ctrl.shiftKind = SH_ROT;
        endcase
      end
      OP_MOVHI: ctrl.unit = UNIT_HIGH;
      OP_MUL: begin
        ctrl.unit = UNIT_MUL;
        ctrl.bSrc = useImm ? SRC_ZEXT : SRC_REG;
      end
      OP_DIV, OP_DIVU: begin
        ctrl.unit      = UNIT_DIV;
        ctrl.divSigned = (opSel == OP_DIV);
        ctrl.bSrc      = useImm ? SRC_ZEXT : SRC_REG;
      end
      default: ctrl.badOp = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int PAD_W   = DATA_W - IMM_W;

  logic [DATA_W-1:0]  opB;
  logic [SHAMT_W-1:0] shamt;

  always_comb begin
    case (ctrl.bSrc)
      SRC_ZEXT:  opB = {{PAD_W{1'b0}}, imm};
      SRC_SEXT:  opB = {{PAD_W{imm[IMM_W-1]}}, imm};
      SRC_SHAMT: opB = {{(DATA_W-SHAMT_W){1'b0}}, imm[SHAMT_W-1:0]};
      default:   opB = srcB;
    endcase
  end
  assign shamt = opB[SHAMT_W-1:0];

  // adder / subtractor
  logic [DATA_W-1:0] sumOut;
  assign sumOut = srcA + (ctrl.negB ? ~opB : opB) + {{(DATA_W-1){1'b0}}, ctrl.negB};

  // bitwise
  logic [DATA_W-1:0] logicOut;
  always_comb begin
    case (ctrl.logicKind)
      LOG_AND: logicOut = srcA & opB;
      LOG_OR:  logicOut = srcA | opB;
      default: logicOut = srcA ^ opB;
    endcase
  end

  // barrel shifter: one right-shifting network; left shift by bit reversal
  logic                          isLeft, isRot, fillBit;
  logic [DATA_W-1:0]             revIn, revOut, shIn, shOut;
  logic [SHAMT_W:0][DATA_W-1:0]  stage;

  assign isLeft  = (ctrl.shiftKind == SH_LEFT);
  assign isRot   = (ctrl.shiftKind == SH_ROT);
  assign fillBit = (ctrl.shiftKind == SH_RARI) & srcA[DATA_W-1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revIn[i]  = srcA[DATA_W-1-i];
    assign revOut[i] = stage[SHAMT_W][DATA_W-1-i];
  end

  assign shIn     = isLeft ? revIn : srcA;
  assign stage[0] = shIn;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [STEP-1:0] upper;
    assign upper = isRot ? stage[s][STEP-1:0] : {STEP{fillBit}};
    assign stage[s+1] = shamt[s] ? {upper, stage[s][DATA_W-1:STEP]} : stage[s];
  end

  assign shOut = isLeft ? revOut : stage[SHAMT_W];

  // load-high
  logic [DATA_W-1:0] highOut;
  assign highOut = {imm, {PAD_W{1'b0}}};

  // multiply, low word only
  logic [DATA_W-1:0] mulOut;
  assign mulOut = srcA * opB;

  // divide on magnitudes, sign restored afterwards
  logic              divZero, aNeg, bNeg;
  logic [DATA_W-1:0] magA, magB, safeB, quotMag, divOut;

  assign divZero = (opB == '0);
  assign aNeg    = ctrl.divSigned & srcA[DATA_W-1];
  assign bNeg    = ctrl.divSigned & opB[DATA_W-1];
  assign magA    = aNeg ? (~srcA + 1'b1) : srcA;
  assign magB    = bNeg ? (~opB + 1'b1) : opB;
  assign safeB   = divZero ? {{(DATA_W-1){1'b0}}, 1'b1} : magB;
  assign quotMag = magA / safeB;
  assign divOut  = (aNeg ^ bNeg) ? (~quotMag + 1'b1) : quotMag;

  // final selection
  always_comb begin
    illegal = ctrl.badOp | ((ctrl.unit == UNIT_DIV) & divZero);
    result  = '0;
    if (!illegal) begin
      case (ctrl.unit)
        UNIT_ADD:   result = sumOut;
        UNIT_LOGIC: result = logicOut;
        UNIT_SHIFT: result = shOut;
        UNIT_HIGH:  result = highOut;
        UNIT_MUL:   result = mulOut;
        UNIT_DIV:   result = divOut;
        default:    result = '0;
      endcase
    end
  end

  // checks on the shifter and the load-high path
  always_comb begin
    if (!$isunknown({ctrl, srcA, opB, imm, result})) begin
      if (ctrl.unit == UNIT_SHIFT && ctrl.shiftKind == SH_RLOG && shamt != '0)
        assert_srl_zero_fill_R4: assert (result[DATA_W-1] == 1'b0)
          else $error("logical right shift left a one in the top bit");
      if (ctrl.unit == UNIT_SHIFT && ctrl.shiftKind == SH_RARI)
        assert_sra_sign_fill_R4: assert (result[DATA_W-1] == srcA[DATA_W-1])
          else $error("arithmetic right shift lost the sign");
      if (ctrl.unit == UNIT_SHIFT && ctrl.shiftKind == SH_ROT)
        assert_rotate_keeps_ones_R5: assert ($countones(result) == $countones(srcA))
          else $error("rotate changed the number of set bits");
      if (ctrl.unit == UNIT_HIGH)
        assert_high_low_clear_R6: assert (result[PAD_W-1:0] == '0)
          else $error("load-high left low bits set");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        opSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  alu_ctrl_t ctrl;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .useImm (useImm),
    .ctrl   (ctrl)
  );

  alu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .imm     (immVal),
    .result  (result),
    .illegal (illegalOp)
  );

  // port-level trap checks across control and datapath
  logic isDiv, zeroDivisor;
  assign isDiv       = (opSel == OP_DIV) || (opSel == OP_DIVU);
  assign zeroDivisor = useImm ? (immVal == '0) : (srcB == '0);

  always_comb begin
    if (!$isunknown({opSel, useImm, srcA, srcB, immVal, result, illegalOp})) begin
      if (isDiv && zeroDivisor)
        assert_zero_div_trap_R10: assert (illegalOp && result == '0)
          else $error("zero divisor did not trap cleanly");
      if (opSel > 4'd12)
        assert_undef_op_trap_R11: assert (illegalOp && result == '0)
          else $error("undefined code did not trap");
      if (opSel <= 4'd12 && !isDiv)
        assert_legal_no_trap_R12: assert (!illegalOp)
          else $error("legal operation flagged illegal");
    end
  end

endmodule

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb_top;

  logic        clk = 1'b0;
  logic [3:0]  opSel = '0;
  logic        useImm = 1'b0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [15:0] immVal = '0;
  logic [31:0] result;
  logic        illegalOp;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu_core dut_i (
    .opSel     (opSel),
    .useImm    (useImm),
    .srcA      (srcA),
    .srcB      (srcB),
    .immVal    (immVal),
    .result    (result),
    .illegalOp (illegalOp)
  );

  // behavioural reference
  function automatic void model(input int op, input bit ui, input bit [31:0] a,
                                input bit [31:0] b, input bit [15:0] im,
                                output bit [31:0] r, output bit ill);
    bit [31:0] zx = {16'h0, im};
    bit [31:0] sx = {{16{im[15]}}, im};
    bit [31:0] bz = ui ? zx : b;
    bit [31:0] bs = ui ? sx : b;
    int        sh = ui ? int'(im[4:0]) : int'(b[4:0]);
    longint    q;
    r = 0; ill = 0;
    case (op)
      0: r = a + bs;
      1: r = a - bs;
      2: r = a & bz;
      3: r = a | bz;
      4: r = a ^ bz;
      5: r = a << sh;
      6: r = a >> sh;
      7: r = $signed(a) >>> sh;
      8: r = (a >> sh) | (a << (32 - sh));
      9: r = {im, 16'h0};
      10: r = a * bz;
      11: if (bz == 0) ill = 1;
          else begin
            q = longint'($signed(a)) / longint'($signed(bz));
            r = q[31:0];
          end
      12: if (bz == 0) ill = 1; else r = a / bz;
      default: ill = 1;
    endcase
  endfunction

  function automatic string reqOf(input int op, input bit ui, input bit ill);
    if (op > 12) return "R11";
    if (ill) return "R10";
    case (op)
      0, 1: return ui ? "R3" : "R1";
      2, 3, 4: return "R2";
      5, 6, 7: return "R4";
      8: return "R5";
      9: return "R6";
      10: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input int op, input bit ui, input bit [31:0] a,
                       input bit [31:0] b, input bit [15:0] im);
    bit [31:0] expR;
    bit        expI;
    string     tag;
    @(posedge clk);
    #1;
    opSel = 4'(op); useImm = ui; srcA = a; srcB = b; immVal = im;
    @(negedge clk);
    model(op, ui, a, b, im, expR, expI);
    tag = reqOf(op, ui, expI);
    total++;
    if (result !== expR) begin
      bad++;
      $display("FAIL %s op=%0d imm=%0b a=%h b=%h i=%h result=%h expected=%h",
               tag, op, ui, a, b, im, result, expR);
    end
    total++;
    if (illegalOp !== expI) begin
      bad++;
      $display("FAIL %s flag op=%0d a=%h b=%h i=%h illegalOp=%0b expected=%0b",
               expI ? tag : "R12", op, a, b, im, illegalOp, expI);
    end
  endtask

  initial begin
    // idle state: all-zero inputs give an add of zeros
    @(negedge clk);
    total++;
    if (result !== 32'h0 || illegalOp !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle result=%h/%0b expected=0/0", result, illegalOp);
    end
    // R1 wraps
    apply(0, 0, 32'hFFFF_FFFF, 32'h1, 16'h0);
    apply(1, 0, 32'h0, 32'h1, 16'h0);
    // R3 sign-extended immediates
    apply(0, 1, 32'h10, 32'hDEAD, 16'h8000);
    apply(0, 1, 32'h10, 32'h0, 16'h7FFF);
    apply(1, 1, 32'h5, 32'h0, 16'hFFFF);
    // R2 zero-extended logic immediates
    apply(2, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
    apply(3, 1, 32'h1234_0000, 32'hFFFF_FFFF, 16'h8000);
    apply(4, 1, 32'hFFFF_FFFF, 32'h0, 16'hF0F0);
    apply(4, 0, 32'hAAAA_5555, 32'h0F0F_0F0F, 16'h0);
    // R4 shifts, upper amount bits ignored
    apply(5, 0, 32'h8000_0001, 32'd33, 16'h0);
    apply(7, 0, 32'h8000_0000, 32'd31, 16'h0);
    apply(6, 0, 32'h8000_0000, 32'd31, 16'h0);
    apply(6, 1, 32'hF000_0000, 32'h0, 16'hFFE3);
    apply(7, 1, 32'h7000_0000, 32'h0, 16'h0024);
    // R5 rotate
    apply(8, 0, 32'h1234_5678, 32'd0, 16'h0);
    apply(8, 0, 32'h0000_0001, 32'd1, 16'h0);
    apply(8, 1, 32'h8000_0001, 32'h0, 16'h001F);
    // R6 load-high ignores the operands
    apply(9, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF);
    apply(9, 1, 32'h1234_5678, 32'h0, 16'h0001);
    // R7 multiply
    apply(10, 0, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0);
    apply(10, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
    // R8 signed divide
    apply(11, 0, 32'hFFFF_FFF9, 32'd2, 16'h0);
    apply(11, 0, 32'd7, 32'hFFFF_FFFE, 16'h0);
    apply(11, 0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
    apply(11, 1, 32'hFFFF_FF00, 32'h0, 16'hFFFF);
    // R9 unsigned divide
    apply(12, 0, 32'hFFFF_FFFF, 32'd2, 16'h0);
    apply(12, 1, 32'd100, 32'h0, 16'd7);
    // R10 zero divisor
    apply(11, 0, 32'h1234, 32'h0, 16'hFFFF);
    apply(12, 1, 32'h1234, 32'h5, 16'h0);
    // R11 undefined codes
    for (int k = 13; k < 16; k++) apply(k, 0, 32'hFFFF_FFFF, 32'h1, 16'h1);
    // random traffic, divisors biased small or zero
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] a = $urandom;
      bit [31:0] b = $urandom;
      bit [15:0] im = 16'($urandom);
      int        op = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) b = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) begin im = 16'($urandom_range(0, 3)); b[31] = ~b[31]; end
      apply(op, 1'($urandom), a, b, im);
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired result=%h expected=completion", result);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule